// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment and a 16-bit offset into a physical address, in the way a processor does in its real addressing mode. The segment value is shifted left by four bits, which is the same as appending a zero nibble, and the offset is added to it. The block holds six segment registers and an instruction pointer. Each of them can be loaded synchronously from a write port.

Each access supplies an offset, the identifier of the pointer register that the offset came from, and an optional segment override. The block picks the segment that belongs to that pointer register, unless the override names another one. An instruction fetch always pairs the code segment with the instruction pointer. The sum can carry into bit 20. An external gate input decides whether that carry reaches the bus or is dropped, which emulates a 1 MB wraparound. Bus lines above bit 20 always read zero.

After reset the code segment and the instruction pointer hold the entry vector, so the first fetch address is FFFF0h.

Top module: `rmag_addr_gen`

## Requirements
- R1: The low 20 bits of `phys_addr` equal (segment × 16 + offset) mod 2^20, where the segment and offset are the ones selected for the current access. For example 1234:5678 gives 179B8h and 8110:091C gives 81A1Ch.
- R2: Bits 31 down to 21 of `phys_addr` read zero at all times.
- R3: Bit 20 of `phys_addr` carries the overflow of the 20-bit sum when `a20_gate` is 1, and is 0 when `a20_gate` is 0. F400:E000 gives 102000h with the gate open and 002000h with it closed.
- R4: After reset the code segment holds F000h and the instruction pointer holds FFF0h, so a fetch gives FFFF0h. The other five segment registers hold 0000h.
- R5: When `fetch_req` is 1, the address is code segment plus instruction pointer. `ofs`, `ptr_id`, `ovr_valid` and `ovr_id` have no effect. For example CS=0400h with IP=0128h gives 04128h.
- R6: For a data access with no override, the default segment is chosen by `ptr_id`. Codes 0, 1, 2, 3, 6 and 7 (the AX, CX, DX, BX, SI and DI pointers) select the data segment. Codes 4 and 5 (SP and BP) select the stack segment.
- R7: For a data access with `ovr_valid` set to 1 and `ovr_id` from 0 to 5, the segment named by `ovr_id` replaces the default. The segment codes are 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS and 5 = GS.
- R8: When `seg_wr_en` is 1 at a rising clock edge, the segment whose code is given by `seg_wr_id` loads `seg_wr_data`. Codes 6 and 7 change no register. Without a write, every segment register keeps its value.
- R9: An override with `ovr_id` equal to 6 or 7 is ignored, and the default segment from R6 is used instead.
- R10: When `ip_wr_en` is 1 at a rising clock edge, the instruction pointer loads `ip_wr_data`. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_id | input | 3 | Code of the segment to write (0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS, 5 = GS) |
| seg_wr_data | input | 16 | Value to load into the segment |
| ip_wr_en | input | 1 | Instruction pointer write strobe |
| ip_wr_data | input | 16 | Value to load into the instruction pointer |
| fetch_req | input | 1 | 1 = instruction fetch (CS:IP), 0 = data access |
| ptr_id | input | 3 | Pointer register code for a data access (0 = AX … 7 = DI) |
| ovr_valid | input | 1 | Segment override present |
| ovr_id | input | 3 | Code of the override segment |
| ofs | input | 16 | Data offset |
| a20_gate | input | 1 | 1 lets the bit-20 carry through, 0 forces bit 20 low |
| phys_addr | output | 32 | Physical address bus |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets, a four-bit shift and a 32-bit bus. With these values a large segment plus a large offset carries into bit 20, so both settings of the gate are exercised, and eleven upper bus lines can be checked for zero. Random segment values, pointer codes, override codes 0 to 7 and fetch requests are mixed with the worked addresses and with writes to the unused codes 6 and 7. This covers every pointer code, every override code and both fetch and data accesses.

// File: rtl/rmag_pkg.sv
package rmag_pkg;
    localparam int ID_W    = 3;
    localparam int NUM_SEG = 6;

    typedef enum logic [ID_W-1:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_code_e;

    typedef enum logic [ID_W-1:0] {
        PTR_AX = 3'd0,
        PTR_CX = 3'd1,
        PTR_DX = 3'd2,
        PTR_BX = 3'd3,
        PTR_SP = 3'd4,
        PTR_BP = 3'd5,
        PTR_SI = 3'd6,
        PTR_DI = 3'd7
    } ptr_code_e;

    // Stack pointers go to the stack segment, all others to the data segment.
    function automatic logic [ID_W-1:0] default_seg(input logic [ID_W-1:0] ptr);
        logic [ID_W-1:0] res;
        case (ptr)
            PTR_SP, PTR_BP: res = SEG_SS;
            default:        res = SEG_DS;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/rmag_seg_file.sv
module rmag_seg_file
    import rmag_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter logic [SEG_W-1:0] CS_RST = 16'hF000,
    parameter logic [OFF_W-1:0] IP_RST = 16'hFFF0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ID_W-1:0]               wr_id,
    input  logic [SEG_W-1:0]              wr_data,
    input  logic                          ipw_en,
    input  logic [OFF_W-1:0]              ipw_data,
    output logic [NUM_SEG-1:0][SEG_W-1:0] seg_q,
    output logic [OFF_W-1:0]              ip_q
);
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL = (k == int'(SEG_CS)) ? CS_RST : '0;
        logic hit;
        assign hit = wr_en && (wr_id == ID_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   seg_q[k] <= RST_VAL;
            else if (hit) seg_q[k] <= wr_data;
        end

        // R8
        seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_id == ID_W'(k)) |=> (seg_q[k] == $past(wr_data)));

        // R8
        seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_id == ID_W'(k)) |=> $stable(seg_q[k]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ip_q <= IP_RST;
        else if (ipw_en) ip_q <= ipw_data;
    end

    // R10
    ip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipw_en |=> (ip_q == $past(ipw_data)));
endmodule

// File: rtl/rmag_seg_select.sv
module rmag_seg_select
    import rmag_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch,
    input  logic [ID_W-1:0] ptr,
    input  logic            ovr_en,
    input  logic [ID_W-1:0] ovr,
    output logic [ID_W-1:0] seg_idx,
    output logic            use_ip
);
    logic ovr_ok;
    assign ovr_ok = ovr_en && (ovr < ID_W'(NUM_SEG));

    always_comb begin
        use_ip = fetch;
        if (fetch)       seg_idx = SEG_CS;
        else if (ovr_ok) seg_idx = ovr;
        else             seg_idx = default_seg(ptr);
    end

    // R5
    fetch_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> (seg_idx == SEG_CS && use_ip));

    // R6
    stack_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && !ovr_en && (ptr == PTR_SP || ptr == PTR_BP)) |-> seg_idx == SEG_SS);

    // R9
    bad_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && ovr_en && ovr >= ID_W'(NUM_SEG)) |-> (seg_idx == SEG_SS || seg_idx == SEG_DS));
endmodule

// File: rtl/rmag_addr_adder.sv
module rmag_addr_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             a20_i,
    output logic [BUS_W-1:0] addr_o
);
    localparam int SUM_W = SEG_W + SHIFT + 1;
    localparam int PAD_W = BUS_W - SUM_W;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] gated;

    assign sum   = SUM_W'({seg_i, {SHIFT{1'b0}}}) + SUM_W'(off_i);
    assign gated = {sum[SUM_W-1] & a20_i, sum[SUM_W-2:0]};
    assign addr_o = {{PAD_W{1'b0}}, gated};

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[BUS_W-1:SUM_W] == '0);

    // R3
    a20_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_i |-> (addr_o[SUM_W-1] == 1'b0));
endmodule

// File: rtl/rmag_addr_gen.sv
module rmag_addr_gen
    import rmag_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int BUS_W = 32,
    parameter logic [SEG_W-1:0] CS_RST = 16'hF000,
    parameter logic [OFF_W-1:0] IP_RST = 16'hFFF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [2:0]       seg_wr_id,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic             ip_wr_en,
    input  logic [OFF_W-1:0] ip_wr_data,
    input  logic             fetch_req,
    input  logic [2:0]       ptr_id,
    input  logic             ovr_valid,
    input  logic [2:0]       ovr_id,
    input  logic [OFF_W-1:0] ofs,
    input  logic             a20_gate,
    output logic [BUS_W-1:0] phys_addr
);
    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
    logic [OFF_W-1:0]              ip_q;
    logic [ID_W-1:0]               seg_idx;
    logic                          use_ip;
    logic [SEG_W-1:0]              seg_val;
    logic [OFF_W-1:0]              off_val;

    rmag_seg_file #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .CS_RST(CS_RST), .IP_RST(IP_RST)
    ) i_seg_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(seg_wr_en), .wr_id(seg_wr_id), .wr_data(seg_wr_data),
        .ipw_en(ip_wr_en), .ipw_data(ip_wr_data),
        .seg_q(seg_q), .ip_q(ip_q)
    );

    rmag_seg_select i_select (
        .clk(clk), .rst_n(rst_n),
        .fetch(fetch_req), .ptr(ptr_id),
        .ovr_en(ovr_valid), .ovr(ovr_id),
        .seg_idx(seg_idx), .use_ip(use_ip)
    );

    always_comb begin
        seg_val = '0;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (seg_idx == ID_W'(k)) seg_val = seg_q[k];
        end
        off_val = use_ip ? ip_q : ofs;
    end

    rmag_addr_adder #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .BUS_W(BUS_W)
    ) i_adder (
        .clk(clk), .rst_n(rst_n),
        .seg_i(seg_val), .off_i(off_val), .a20_i(a20_gate),
        .addr_o(phys_addr)
    );
endmodule

// File: tb/test_rmag_addr_gen.sv
module test_rmag_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [2:0]  seg_wr_id = '0;
    logic [15:0] seg_wr_data = '0;
    logic        ip_wr_en = 1'b0;
    logic [15:0] ip_wr_data = '0;
    logic        fetch_req = 1'b0;
    logic [2:0]  ptr_id = '0;
    logic        ovr_valid = 1'b0;
    logic [2:0]  ovr_id = '0;
    logic [15:0] ofs = '0;
    logic        a20_gate = 1'b0;
    logic [31:0] phys_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_seg [6];
    logic [15:0] m_ip;

    always #4 clk = ~clk;

    rmag_addr_gen i_rmag_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_id(seg_wr_id), .seg_wr_data(seg_wr_data),
        .ip_wr_en(ip_wr_en), .ip_wr_data(ip_wr_data),
        .fetch_req(fetch_req), .ptr_id(ptr_id),
        .ovr_valid(ovr_valid), .ovr_id(ovr_id),
        .ofs(ofs), .a20_gate(a20_gate),
        .phys_addr(phys_addr)
    );

    function automatic logic [31:0] exp_addr(input logic [15:0] s, input logic [15:0] o,
                                             input logic g);
        logic [20:0] sum;
        sum = {1'b0, s, 4'h0} + {5'h0, o};
        if (!g) sum[20] = 1'b0;
        return {11'h0, sum};
    endfunction

    // R5 fetch -> CS (1); R7/R9 override codes 0..5 valid; R6 SP/BP (4,5) -> SS (2) else DS (3)
    function automatic int exp_seg(input logic f, input logic [2:0] p, input logic ov,
                                   input logic [2:0] oid);
        if (f) return 1;
        if (ov && oid < 3'd6) return int'(oid);
        if (p == 3'd4 || p == 3'd5) return 2;
        return 3;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        seg_wr_en = 1'b0; ip_wr_en = 1'b0;
        fetch_req = 1'b0; ovr_valid = 1'b0;
        ptr_id = '0; ovr_id = '0; ofs = '0; a20_gate = 1'b0;
    endtask

    task automatic wr_seg(input logic [2:0] id, input logic [15:0] v);
        @(negedge clk);
        idle_inputs();
        seg_wr_en = 1'b1; seg_wr_id = id; seg_wr_data = v;
        if (id < 3'd6) m_seg[id] = v;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic wr_ip(input logic [15:0] v);
        @(negedge clk);
        idle_inputs();
        ip_wr_en = 1'b1; ip_wr_data = v; m_ip = v;
        @(negedge clk);
        ip_wr_en = 1'b0;
    endtask

    task automatic access(input string req, input logic f, input logic [2:0] p, input logic ov,
                          input logic [2:0] oid, input logic [15:0] o, input logic g,
                          input logic [31:0] exp);
        @(negedge clk);
        idle_inputs();
        fetch_req = f; ptr_id = p; ovr_valid = ov; ovr_id = oid; ofs = o; a20_gate = g;
        #1;
        check(req, phys_addr, exp);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1729);
        m_seg[0] = 16'h0; m_seg[1] = 16'hF000; m_seg[2] = 16'h0;
        m_seg[3] = 16'h0; m_seg[4] = 16'h0;    m_seg[5] = 16'h0;
        m_ip = 16'hFFF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset vector and reset segment values
        access("R4 reset fetch", 1'b1, 3'd0, 1'b0, 3'd0, 16'h1234, 1'b1, 32'h000FFFF0);
        for (int k = 0; k < 6; k++)
            access("R4 reset segment", 1'b0, 3'd0, 1'b1, 3'(k), 16'h0, 1'b1,
                   (k == 1) ? 32'h000F0000 : 32'h0);

        // R1 worked addresses
        wr_seg(3'd3, 16'h1234);
        access("R1 1234:5678", 1'b0, 3'd3, 1'b0, 3'd0, 16'h5678, 1'b0, 32'h000179B8);
        wr_seg(3'd3, 16'h8110);
        access("R1 8110:091C", 1'b0, 3'd6, 1'b0, 3'd0, 16'h091C, 1'b0, 32'h00081A1C);

        // R5 fetch uses CS:IP and ignores offset and override
        wr_seg(3'd1, 16'h0400);
        wr_ip(16'h0128);
        access("R5 fetch 0400:0128", 1'b1, 3'd4, 1'b1, 3'd0, 16'hFFFF, 1'b1, 32'h00004128);

        // R3 carry gating
        wr_seg(3'd0, 16'hF400);
        access("R3 gate open", 1'b0, 3'd0, 1'b1, 3'd0, 16'hE000, 1'b1, 32'h00102000);
        access("R3 gate closed", 1'b0, 3'd0, 1'b1, 3'd0, 16'hE000, 1'b0, 32'h00002000);
        wr_seg(3'd5, 16'hFFFF);
        access("R3 max open", 1'b0, 3'd0, 1'b1, 3'd5, 16'hFFFF, 1'b1, 32'h0010FFEF);
        access("R2 max upper zero", 1'b0, 3'd0, 1'b1, 3'd5, 16'hFFFF, 1'b1, 32'h0010FFEF);

        // R6 default segments: SS for BP, DS for BX
        wr_seg(3'd2, 16'h3000);
        access("R6 BP uses SS", 1'b0, 3'd5, 1'b0, 3'd0, 16'hFFFC, 1'b0, 32'h0003FFFC);
        wr_seg(3'd3, 16'h0125);
        access("R6 BX uses DS", 1'b0, 3'd3, 1'b0, 3'd0, 16'h0050, 1'b0, 32'h000012A0);

        // R7 override to ES
        access("R7 ES override", 1'b0, 3'd3, 1'b1, 3'd0, 16'h0000, 1'b1, 32'h000F4000);
        // R9 invalid override code falls back to default
        access("R9 override 7", 1'b0, 3'd3, 1'b1, 3'd7, 16'h0050, 1'b0, 32'h000012A0);

        // R8 writes to codes 6 and 7 change nothing
        wr_seg(3'd6, 16'hABCD);
        wr_seg(3'd7, 16'h5555);
        for (int k = 0; k < 6; k++)
            access("R8 unused code write", 1'b0, 3'd0, 1'b1, 3'(k), 16'h0, 1'b1,
                   exp_addr(m_seg[k], 16'h0, 1'b1));

        // Random mix: R1, R2, R3, R5, R6, R7, R8, R9, R10
        for (int it = 0; it < 4000; it++) begin
            int s;
            @(negedge clk);
            seg_wr_en   = ($urandom % 4) == 0;
            seg_wr_id   = 3'($urandom % 8);
            seg_wr_data = ($urandom % 2) ? 16'($urandom) : 16'hF000 | 16'($urandom % 4096);
            ip_wr_en    = ($urandom % 6) == 0;
            ip_wr_data  = 16'($urandom);
            fetch_req   = ($urandom % 5) == 0;
            ptr_id      = 3'($urandom % 8);
            ovr_valid   = ($urandom % 3) == 0;
            ovr_id      = 3'($urandom % 8);
            ofs         = 16'($urandom);
            a20_gate    = 1'($urandom % 2);
            #1;
            s = exp_seg(fetch_req, ptr_id, ovr_valid, ovr_id);
            check("R1/R3/R5/R6/R7/R9 random",
                  phys_addr, exp_addr(m_seg[s], fetch_req ? m_ip : ofs, a20_gate));
            if (seg_wr_en && seg_wr_id < 3'd6) m_seg[seg_wr_id] = seg_wr_data;
            if (ip_wr_en) m_ip = ip_wr_data;
        end
        @(negedge clk);
        idle_inputs();
        // R10 final instruction pointer visible through a fetch
        access("R10 final fetch", 1'b1, 3'd0, 1'b0, 3'd0, 16'h0, 1'b1,
               exp_addr(m_seg[1], m_ip, 1'b1));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule